// File: doc/BRIEF.md
# Pluggable Module Identity Reader

This block sits on the host side of a cage for a pluggable optical module. When software or a sequencer requests a read, and the module's ground-tied presence pin shows that a module is seated, the block runs a two-wire serial transfer on an open-drain clock and data pair. The transfer pulls the 128-byte identity map out of the module's serial memory and stores it in a local shadow copy. The host can read the copy one byte at a time through an address and data port.

The block accumulates two checksums while the bytes stream in. One covers the base region and the other covers the extended region, and each is compared against the checksum byte stored in the map. The block then reports the outcome on four flags: valid, bus error (missing acknowledge), base checksum error and extended checksum error.

Bit timing comes from a parameterised divider. The clock high and low times are each two quarter-bit slots of `CLK_DIV` system clocks, so a slow bus clock can be reached from any system clock. Removing the module mid-transfer abandons the transfer at once.

Top module: `pluggable_id_reader`

## Requirements
- R1: After reset, busy, valid and all three error flags are low, and both bus lines are released (scl_oe = 0, sda_oe = 0).
- R2: A start pulse is accepted only while mod_present_n is low (module inserted). A start pulse while it is high leaves busy low and produces no bus activity.
- R3: One read consists of the following, in order:
  - a start condition;
  - device byte 0xA0, then word address 0x00;
  - a repeated start, then device byte 0xA1;
  - 128 bytes read sequentially, where the controller acknowledges the first 127 and not-acknowledges the last;
  - a stop condition.
- R4: The lines are only ever pulled low (output enable = 1) or released. Whenever busy is low, both enables are 0.
- R5: During a data bit, the clock line stays released for exactly 2*CLK_DIV system clocks.
- R6: After a read completes, rd_data returns the byte that the module holds at rd_addr, for every address 0 to 127.
- R7: The base checksum is the low 8 bits of the sum of bytes 0 to 62, and it must equal byte 63. On a mismatch, err_base_sum goes high at completion.
- R8: The extended checksum is the low 8 bits of the sum of bytes 64 to 94, and it must equal byte 95. On a mismatch, err_ext_sum goes high at completion, independently of R7.
- R9: valid goes high at completion only if every byte was acknowledged and both checksums match. valid is never high together with an error flag. A new accepted start clears valid and all error flags.
- R10: If the module does not acknowledge a device or address byte, the controller issues a stop, raises err_nack, leaves valid low and returns to idle. The checksum flags stay low in that case.
- R11: If mod_present_n goes high during a read, the read is abandoned: busy falls, both lines are released and valid is low within SYNC_STAGES+1 clocks. Removal while idle also clears valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_present_n | input | 1 | Presence pin, low when a module is seated |
| start | input | 1 | One-cycle request to read the identity map |
| scl_oe | output | 1 | Pull the serial clock line low when 1 |
| sda_oe | output | 1 | Pull the serial data line low when 1 |
| sda_in | input | 1 | Resolved level of the serial data line |
| rd_addr | input | 7 | Shadow copy byte address |
| rd_data | output | 8 | Shadow copy byte at rd_addr |
| busy | output | 1 | A read is in progress |
| valid | output | 1 | Last read completed with both checksums correct |
| err_nack | output | 1 | A device or address byte was not acknowledged |
| err_base_sum | output | 1 | Base region checksum mismatch |
| err_ext_sum | output | 1 | Extended region checksum mismatch |

## Verification
The assertions rely on three assumptions about the environment:
- the module never stretches the clock;
- the module changes the data line only while the clock line is low;
- the presence pin and the data line settle within the synchronizer depth, so `CLK_DIV` must exceed `SYNC_STAGES`.

The bench's memory model keeps to these limits. It drives or releases data only on falling clock edges and acknowledges by pulling data low. It runs with `CLK_DIV` = 3, which exceeds the two synchronizer stages. The presence pin is toggled only on falling system clock edges, and the bench allows for the synchronizer delay before it looks at busy or valid.

// File: rtl/idrd_pkg.sv
package idrd_pkg;
  // identity map layout
  localparam int MAP_BYTES = 128;
  localparam int IDX_W     = $clog2(MAP_BYTES);
  localparam int BASE_CK   = 63;   // checksum byte over 0..62
  localparam int EXT_LO    = 64;
  localparam int EXT_CK    = 95;   // checksum byte over 64..94
  localparam logic [6:0] DEV_ID = 7'h50;

  typedef enum logic [1:0] {OP_START, OP_STOP, OP_WRITE, OP_READ} bus_op_e;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_START1, SQ_DEVW, SQ_WADDR, SQ_START2, SQ_DEVR, SQ_READ, SQ_STOP
  } seq_e;

  function automatic logic [7:0] csum_step(logic [7:0] acc, logic [7:0] b);
    return acc + b;
  endfunction

  function automatic logic in_base(logic [IDX_W-1:0] idx);
    return idx < IDX_W'(BASE_CK);
  endfunction

  function automatic logic in_ext(logic [IDX_W-1:0] idx);
    return (idx >= IDX_W'(EXT_LO)) && (idx < IDX_W'(EXT_CK));
  endfunction
endpackage

// File: rtl/idrd_sync.sv
module idrd_sync #(
  parameter int   STAGES  = 2,     // must be 2 or more
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/idrd_bit_eng.sv
module idrd_bit_eng import idrd_pkg::*; #(
  parameter int CLK_DIV = 250      // system clocks per quarter bit
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       cmd_valid,
  input  bus_op_e    cmd_op,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_ack,      // controller acknowledges a read byte
  input  logic       sda_s,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic       done,
  output logic       ack_seen,
  output logic [7:0] rx_byte
);
  localparam int CNT_W = $clog2(CLK_DIV + 1);

  typedef enum logic [1:0] {E_IDLE, E_START, E_BITS, E_STOP} eng_e;

  eng_e             st;
  logic [1:0]       ph;
  logic [3:0]       bitn;
  logic [7:0]       sh;
  logic             is_rd, mack;
  logic [CNT_W-1:0] cnt;

  wire tick     = (st != E_IDLE) && (cnt == CNT_W'(CLK_DIV - 1));
  wire ack_slot = (bitn == 4'd8);
  wire finish   = tick && (ph == 2'd3) && ((st != E_BITS) || ack_slot);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= E_IDLE; ph <= '0; bitn <= '0; sh <= '0; is_rd <= 1'b0; mack <= 1'b0;
      cnt <= '0; scl_oe <= 1'b0; sda_oe <= 1'b0; done <= 1'b0; ack_seen <= 1'b0;
    end else if (abort) begin
      st <= E_IDLE; ph <= '0; cnt <= '0;
      scl_oe <= 1'b0; sda_oe <= 1'b0; done <= 1'b0;
    end else begin
      done <= finish;
      if (st == E_IDLE) begin
        cnt <= '0;
        ph  <= '0;
        if (cmd_valid) begin
          bitn  <= '0;
          sh    <= cmd_byte;
          is_rd <= (cmd_op == OP_READ);
          mack  <= cmd_ack;
          case (cmd_op)
            OP_START: st <= E_START;
            OP_STOP:  st <= E_STOP;
            default:  st <= E_BITS;
          endcase
        end
      end else begin
        cnt <= tick ? '0 : cnt + 1'b1;
        if (tick) begin
          ph <= ph + 2'd1;
          case (st)
            E_START: begin
              case (ph)
                2'd0:    sda_oe <= 1'b0;
                2'd1:    scl_oe <= 1'b0;
                2'd2:    sda_oe <= 1'b1;
                default: scl_oe <= 1'b1;
              endcase
            end
            E_BITS: begin
              case (ph)
                2'd0:    sda_oe <= ack_slot ? (is_rd & mack) : (~is_rd & ~sh[7]);
                2'd1:    scl_oe <= 1'b0;
                2'd2:    if (ack_slot) ack_seen <= ~sda_s;
                         else          sh <= {sh[6:0], sda_s};
                default: begin scl_oe <= 1'b1; bitn <= bitn + 4'd1; end
              endcase
            end
            E_STOP: begin
              case (ph)
                2'd0:    sda_oe <= 1'b1;
                2'd1:    scl_oe <= 1'b0;
                2'd2:    sda_oe <= 1'b0;
                default: ;
              endcase
            end
            default: ;
          endcase
          if (finish) st <= E_IDLE;
        end
      end
    end
  end

  assign rx_byte = sh;
endmodule

// File: rtl/idrd_csum.sv
module idrd_csum import idrd_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             byte_vld,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic             base_ok,
  output logic             ext_ok
);
  logic [7:0] sum_b, ck_b, sum_e, ck_e;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_b <= '0; ck_b <= '0; sum_e <= '0; ck_e <= '0;
    end else if (clr) begin
      sum_b <= '0; ck_b <= '0; sum_e <= '0; ck_e <= '0;
    end else if (byte_vld) begin
      if (in_base(idx))               sum_b <= csum_step(sum_b, data);
      if (idx == IDX_W'(BASE_CK))     ck_b  <= data;
      if (in_ext(idx))                sum_e <= csum_step(sum_e, data);
      if (idx == IDX_W'(EXT_CK))      ck_e  <= data;
    end
  end

  assign base_ok = (sum_b == ck_b);
  assign ext_ok  = (sum_e == ck_e);
endmodule

// File: rtl/pluggable_id_reader.sv
module pluggable_id_reader import idrd_pkg::*; #(
  parameter int CLK_DIV     = 250,  // quarter bit; must exceed SYNC_STAGES
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mod_present_n,
  input  logic             start,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             valid,
  output logic             err_nack,
  output logic             err_base_sum,
  output logic             err_ext_sum
);
  logic             absent_s, sda_s;
  seq_e             sq;
  logic             cmd_pend;
  logic [IDX_W-1:0] idx;
  logic [7:0]       shadow [MAP_BYTES];
  bus_op_e          op;
  logic [7:0]       op_byte;
  logic             eng_done, eng_ack, base_ok, ext_ok;
  logic [7:0]       eng_rx;

  idrd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_pres (
    .clk(clk), .rst_n(rst_n), .d(mod_present_n), .q(absent_s));
  idrd_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda (
    .clk(clk), .rst_n(rst_n), .d(sda_in), .q(sda_s));

  // named events
  wire accept    = start && !absent_s && (sq == SQ_IDLE);
  wire removed   = absent_s && (sq != SQ_IDLE);
  wire byte_in   = eng_done && (sq == SQ_READ);
  wire last_byte = (idx == IDX_W'(MAP_BYTES - 1));
  wire ctl_byte  = (sq == SQ_DEVW) || (sq == SQ_WADDR) || (sq == SQ_DEVR);
  wire nack_fail = eng_done && ctl_byte && !eng_ack;
  wire finish    = eng_done && (sq == SQ_STOP);

  always_comb begin
    op_byte = 8'h00;
    case (sq)
      SQ_START1, SQ_START2: op = OP_START;
      SQ_DEVW:  begin op = OP_WRITE; op_byte = {DEV_ID, 1'b0}; end
      SQ_WADDR: begin op = OP_WRITE; op_byte = 8'h00;          end
      SQ_DEVR:  begin op = OP_WRITE; op_byte = {DEV_ID, 1'b1}; end
      SQ_READ:  op = OP_READ;
      default:  op = OP_STOP;
    endcase
  end

  idrd_bit_eng #(.CLK_DIV(CLK_DIV)) u_eng (
    .clk(clk), .rst_n(rst_n), .abort(removed),
    .cmd_valid(cmd_pend), .cmd_op(op), .cmd_byte(op_byte), .cmd_ack(!last_byte),
    .sda_s(sda_s), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .done(eng_done), .ack_seen(eng_ack), .rx_byte(eng_rx));

  idrd_csum u_sum (
    .clk(clk), .rst_n(rst_n), .clr(accept), .byte_vld(byte_in),
    .idx(idx), .data(eng_rx), .base_ok(base_ok), .ext_ok(ext_ok));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq <= SQ_IDLE; cmd_pend <= 1'b0; idx <= '0; valid <= 1'b0;
      err_nack <= 1'b0; err_base_sum <= 1'b0; err_ext_sum <= 1'b0;
    end else begin
      cmd_pend <= 1'b0;
      if (absent_s) begin
        sq    <= SQ_IDLE;
        valid <= 1'b0;
      end else if (accept) begin
        sq <= SQ_START1; cmd_pend <= 1'b1; idx <= '0; valid <= 1'b0;
        err_nack <= 1'b0; err_base_sum <= 1'b0; err_ext_sum <= 1'b0;
      end else if (eng_done) begin
        cmd_pend <= 1'b1;
        if (nack_fail) err_nack <= 1'b1;
        case (sq)
          SQ_START1: sq <= SQ_DEVW;
          SQ_DEVW:   sq <= eng_ack ? SQ_WADDR  : SQ_STOP;
          SQ_WADDR:  sq <= eng_ack ? SQ_START2 : SQ_STOP;
          SQ_START2: sq <= SQ_DEVR;
          SQ_DEVR:   sq <= eng_ack ? SQ_READ   : SQ_STOP;
          SQ_READ:   if (last_byte) sq <= SQ_STOP;
                     else           idx <= idx + 1'b1;
          default: begin
            sq           <= SQ_IDLE;
            cmd_pend     <= 1'b0;
            valid        <= !err_nack && base_ok && ext_ok;
            err_base_sum <= !err_nack && !base_ok;
            err_ext_sum  <= !err_nack && !ext_ok;
          end
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (byte_in) shadow[idx] <= eng_rx;
  end

  assign rd_data = shadow[rd_addr];
  assign busy    = (sq != SQ_IDLE);
endmodule

// File: rtl/pluggable_id_reader_chk.sv
module pluggable_id_reader_chk (
  input logic clk,
  input logic rst_n,
  input logic absent_s,
  input logic start,
  input logic busy,
  input logic valid,
  input logic err_nack,
  input logic err_base_sum,
  input logic err_ext_sum,
  input logic scl_oe,
  input logic sda_oe,
  input logic finish
);
  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe)); // R4

  AST_START_NEEDS_MODULE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && absent_s && !busy) |=> !busy); // R2

  AST_ABSENT_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    absent_s |=> (!busy && !valid)); // R11

  AST_VALID_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> !(err_nack || err_base_sum || err_ext_sum)); // R9

  AST_NACK_NO_SUM_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    err_nack |-> (!err_base_sum && !err_ext_sum && !valid)); // R10

  AST_VALID_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(valid) |-> $past(finish)); // R9
endmodule

bind pluggable_id_reader pluggable_id_reader_chk u_chk (
  .clk(clk), .rst_n(rst_n), .absent_s(absent_s), .start(start), .busy(busy),
  .valid(valid), .err_nack(err_nack), .err_base_sum(err_base_sum),
  .err_ext_sum(err_ext_sum), .scl_oe(scl_oe), .sda_oe(sda_oe), .finish(finish));

// File: tb/sim_pluggable_id_reader.sv
`timescale 1ns/100ps
module sim_pluggable_id_reader;
  localparam int DIV = 3;

  logic clk = 1'b0, rst_n = 1'b0, pres_n = 1'b1, start = 1'b0;
  logic [6:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic scl_oe, sda_oe, busy, valid, err_nack, err_base_sum, err_ext_sum;
  logic s_drv = 1'b0;
  wire  scl_line = ~scl_oe;
  wire  sda_line = ~(sda_oe | s_drv);

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  pluggable_id_reader #(.CLK_DIV(DIV), .SYNC_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .mod_present_n(pres_n), .start(start),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .valid(valid),
    .err_nack(err_nack), .err_base_sum(err_base_sum), .err_ext_sum(err_ext_sum));

  // ---------------- memory model of the module ----------------
  logic [7:0] img [128];
  int s_state = 0, s_bit = 0, s_sent = 0, s_mack = 0, s_mnack = 0;
  int s_starts = 0, s_stops = 0, s_nlog = 0;
  logic s_ack = 1'b0, s_rd = 1'b0, s_done_rd = 1'b0, s_refuse = 1'b0;
  logic [7:0] s_sh = '0, s_waddr = 8'hff;
  logic [6:0] s_ptr = '0;
  logic [7:0] s_log [4];
  time  t_rise = 0;
  int   hi_len = 0;

  always @(negedge sda_line) if (scl_line === 1'b1) begin
    s_state = 1; s_bit = 0; s_ack = 1'b0; s_drv = 1'b0; s_starts++;
  end

  always @(posedge sda_line) if (scl_line === 1'b1 && rst_n) begin
    s_state = 0; s_drv = 1'b0; s_stops++;
  end

  always @(posedge scl_line) begin
    t_rise = $time;
    if ((s_state == 1 || s_state == 2) && !s_ack && s_bit < 8) begin
      s_sh = {s_sh[6:0], sda_line}; s_bit++;
    end else if (s_state == 3 && s_ack) begin
      if (sda_line) begin s_mnack++; s_done_rd = 1'b1; end
      else s_mack++;
    end
  end

  always @(negedge scl_line) begin
    hi_len = int'(($time - t_rise) / 5);
    if (s_state == 1 || s_state == 2) begin
      if (s_ack) begin
        s_ack = 1'b0; s_drv = 1'b0; s_bit = 0;
        if (s_rd) begin
          s_state = 3; s_done_rd = 1'b0; s_drv = ~img[s_ptr][7]; s_sent++;
        end else s_state = 2;
      end else if (s_bit == 8) begin
        if (s_state == 1) begin
          if (s_nlog < 4) s_log[s_nlog] = s_sh;
          s_nlog++;
          if (s_sh[7:1] == 7'h50 && !s_refuse) begin
            s_ack = 1'b1; s_drv = 1'b1; s_rd = s_sh[0];
          end else s_state = 0;
        end else begin
          s_waddr = s_sh; s_ptr = s_sh[6:0]; s_ack = 1'b1; s_drv = 1'b1; s_rd = 1'b0;
        end
      end
    end else if (s_state == 3) begin
      if (s_ack) begin
        s_ack = 1'b0; s_bit = 0;
        if (s_done_rd) begin s_state = 0; s_drv = 1'b0; end
        else begin s_ptr = s_ptr + 7'd1; s_drv = ~img[s_ptr][7]; s_sent++; end
      end else begin
        s_bit++;
        if (s_bit == 8) begin s_drv = 1'b0; s_ack = 1'b1; end
        else s_drv = ~img[s_ptr][7 - s_bit];
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  // fill the image; checksums correct unless corrupted afterwards
  task automatic build_img(input int seed);
    int sb, se;
    for (int i = 0; i < 128; i++) img[i] = 8'((i * seed) ^ (i >> 2) ^ (seed << 3));
    sb = 0; se = 0;
    for (int i = 0; i <= 62; i++) sb += img[i];
    for (int i = 64; i <= 94; i++) se += img[i];
    img[63] = 8'(sb);
    img[95] = 8'(se);
  endtask

  task automatic clr_log();
    s_sent = 0; s_mack = 0; s_mnack = 0; s_nlog = 0; s_waddr = 8'hff;
    s_starts = 0; s_stops = 0;
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 30000) begin @(negedge clk); n++; end
  endtask

  task automatic sweep_shadow(input string req);
    int bad = 0, first_a = -1, first_v = 0;
    for (int a = 0; a < 128; a++) begin
      @(negedge clk) rd_addr = 7'(a);
      #1;
      if (rd_data !== img[a]) begin
        bad++;
        if (first_a < 0) begin first_a = a; first_v = int'(rd_data); end
      end
    end
    chk(bad == 0, req, $sformatf("shadow bytes wrong (first addr %0d)", first_a),
        first_v, (first_a < 0) ? 0 : int'(img[first_a]));
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy == 0 && valid == 0, "R1", "busy/valid after reset", {busy, valid}, 0);
    chk({err_nack, err_base_sum, err_ext_sum} == 3'b000, "R1", "error flags after reset",
        {err_nack, err_base_sum, err_ext_sum}, 0);
    chk(scl_oe == 0 && sda_oe == 0, "R1", "lines released after reset", {scl_oe, sda_oe}, 0);

    // R2 start without module
    clr_log();
    pulse_start();
    repeat (60) @(negedge clk);
    chk(busy == 0, "R2", "busy with module absent", busy, 0);
    chk(s_starts == 0, "R2", "bus start conditions with module absent", s_starts, 0);

    pres_n = 1'b0;
    repeat (5) @(negedge clk);

    // good image, first pattern
    build_img(7);
    clr_log();
    pulse_start();
    chk(busy == 1, "R2", "busy after accepted start", busy, 1);
    wait_idle();
    chk(valid == 1, "R9", "valid after clean read", valid, 1);
    chk({err_nack, err_base_sum, err_ext_sum} == 3'b000, "R9", "errors after clean read",
        {err_nack, err_base_sum, err_ext_sum}, 0);
    chk(scl_oe == 0 && sda_oe == 0, "R4", "lines released after read", {scl_oe, sda_oe}, 0);
    chk(s_nlog == 2 && s_log[0] == 8'hA0 && s_log[1] == 8'hA1, "R3", "device bytes A0/A1",
        {s_log[0], s_log[1]}, 16'hA0A1);
    chk(s_waddr == 8'h00, "R3", "word address", s_waddr, 0);
    chk(s_sent == 128, "R3", "bytes transferred", s_sent, 128);
    chk(s_mack == 127 && s_mnack == 1, "R3", "controller acks/nacks", s_mack * 1000 + s_mnack, 127001);
    chk(s_starts == 2 && s_stops == 1, "R3", "start/stop count", s_starts * 10 + s_stops, 21);
    chk(hi_len == 2 * DIV, "R5", "clock high time in clocks", hi_len, 2 * DIV);
    sweep_shadow("R6");

    // base checksum corrupted
    build_img(13);
    img[63] = img[63] ^ 8'h01;
    clr_log();
    pulse_start();
    wait_idle();
    chk(err_base_sum == 1 && err_ext_sum == 0, "R7", "base mismatch flags",
        {err_base_sum, err_ext_sum}, 2);
    chk(valid == 0, "R7", "valid with bad base sum", valid, 0);
    sweep_shadow("R6");

    // extended checksum corrupted (in a covered byte)
    build_img(29);
    img[80] = img[80] + 8'd5;
    clr_log();
    pulse_start();
    wait_idle();
    chk(err_ext_sum == 1 && err_base_sum == 0, "R8", "ext mismatch flags",
        {err_base_sum, err_ext_sum}, 1);
    chk(valid == 0, "R8", "valid with bad ext sum", valid, 0);

    // device refuses address
    build_img(3);
    s_refuse = 1'b1;
    clr_log();
    pulse_start();
    wait_idle();
    s_refuse = 1'b0;
    chk(err_nack == 1, "R10", "nack flag", err_nack, 1);
    chk(valid == 0 && err_base_sum == 0 && err_ext_sum == 0, "R10", "valid/sum flags on nack",
        {valid, err_base_sum, err_ext_sum}, 0);
    chk(s_stops == 1 && s_sent == 0, "R10", "stop issued, no data", s_stops * 1000 + s_sent, 1000);

    // clean read clears old errors
    build_img(101);
    clr_log();
    pulse_start();
    chk(err_nack == 0, "R9", "error cleared on new start", err_nack, 0);
    wait_idle();
    chk(valid == 1, "R9", "valid after second pattern", valid, 1);
    sweep_shadow("R6");

    // removal while idle clears valid
    @(negedge clk) pres_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(valid == 0, "R11", "valid after idle removal", valid, 0);
    pres_n = 1'b0;
    repeat (4) @(negedge clk);

    // removal during a read
    clr_log();
    pulse_start();
    while (s_sent < 10) @(negedge clk);
    pres_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && valid == 0, "R11", "busy/valid after removal", {busy, valid}, 0);
    chk(scl_oe == 0 && sda_oe == 0, "R11", "lines after removal", {scl_oe, sda_oe}, 0);

    summary();
    $finish;
  end
endmodule